// File: doc/BRIEF.md
# UART Extended Configuration Register Bank

This block is the host-facing register decoder of one UART channel. A CPU reaches it over a byte-wide bus with a 3-bit address, a write strobe and a read strobe. The block holds the channel configuration registers: the 16-bit baud divisor, the line control and modem control bytes, a scratch byte and a feature control byte. It drives the configuration outputs that the serial engine and the pad logic consume: the divisor, the RX and TX trigger levels, the RTS hysteresis select, the inverted or plain IrDA receive line, and the OP1 output.

The line control byte selects the register bank. When its top bit is set, the two low offsets reach the divisor bytes. When it holds a configurable key value (0xBF by default), an extended bank appears. In that bank the FIFO character count, the trigger level and the feature control byte sit at the upper offsets. While the divisor is zero, the two low offsets return a device ID and a revision code. A direction bit in the feature control byte steers the shared trigger and count locations between the receive and transmit FIFO. A swap bit turns scratch byte reads into FIFO level reads. FIFO occupancy counts arrive as inputs. The FIFOs, the serial engine and interrupt logic live elsewhere.

Reads are registered: the byte selected in a cycle with `rd_en` high appears on `rdata` after that clock edge and holds until the next read.

Top module: `uxr_regbank`

## Requirements
- R1: After reset the divisor, both trigger levels, line control, modem control, feature control and scratch byte are all 0x00, so `rts_hyst`=0, `op1_out`=0 and `irda_rx_out` equals `rx_in`.
- R2: Offset 3 (line control) and offset 4 (modem control) are read/write in every bank. Their contents appear on `lcr_cfg` and `mcr_cfg`.
- R3: With line control bit 7 set, offset 0 reads and writes the divisor low byte and offset 1 the high byte, and `divisor` = {high, low}. With bit 7 clear, offsets 0, 1 and 2 read 0x00 and writes to them change no held register.
- R4: The extended bank is active only while line control equals the key (0xBF). Outside it, offsets 5 and 6 read 0x00, writes to them have no effect, and offset 7 is the scratch byte. Inside it, offset 7 is the feature control byte, fully readable.
- R5: In the extended bank, reads of offset 0 return the device ID (0x14) and reads of offset 1 return the revision (0x01) while the divisor is 0x0000. Otherwise they return the divisor bytes. Writes there always reach the divisor.
- R6: In the extended bank, a write to offset 6 sets `rx_trig` when feature control bit 7 is 0 and `tx_trig` when it is 1; the other level is unchanged. Reads of offset 6 return 0x00.
- R7: In the extended bank, offset 5 reads `tx_fifo_cnt` when feature control bit 7 is 1 and `rx_fifo_cnt` when it is 0. Writes to offset 5 change no held register.
- R8: Outside the extended bank, with feature control bit 6 set, a read of offset 7 returns the FIFO count selected by bit 7 instead of the scratch byte. Writes still update the scratch byte, which reads back once bit 6 is cleared.
- R9: `rts_hyst` equals feature control bits [1:0].
- R10: `irda_rx_out` equals `rx_in` inverted when feature control bit 2 is 1, and equals `rx_in` unchanged when it is 0.
- R11: `op1_out` follows modem control bit 2 when feature control bit 3 is 0, and follows `rs485_dir` when it is 1.
- R12: `rdata` takes the value selected in the cycle `rd_en` is high, at that clock edge, and keeps it while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_fifo_cnt | input | CNT_W | Receive FIFO character count |
| tx_fifo_cnt | input | CNT_W | Transmit FIFO character count |
| rs485_dir | input | 1 | Half-duplex direction signal from the transmitter |
| rx_in | input | 1 | Raw receive line |
| divisor | output | 16 | Baud divisor; bit rate = clock / 16 / divisor |
| rx_trig | output | 8 | Receive trigger level |
| tx_trig | output | 8 | Transmit trigger level |
| rts_hyst | output | 2 | RTS hysteresis select |
| irda_rx_out | output | 1 | Receive line toward the IrDA decoder |
| op1_out | output | 1 | OP1 output |
| lcr_cfg | output | 8 | Line control byte |
| mcr_cfg | output | 8 | Modem control byte |

## Verification
The bench builds the block with its default parameters: an 8-bit count width, the 0xBF bank key, ID 0x14 and revision 0x01. Every register value and the full count range from 0 to 255 are therefore reachable. The random line control writes are biased toward 0x00, 0x80 and the key, so all three banks are visited often. About a quarter of divisor writes use zero data, so the divisor returns to zero and the ID/revision switch in the extended bank is exercised repeatedly.

// File: rtl/uxr_pkg.sv
// Shared types and constants for the UART extended register bank.
// Assumes a byte-wide data bus and a 3-bit offset space.
package uxr_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    // Register offsets whose position the bank decode depends on
    localparam logic [ADDR_W-1:0] OFS_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_DIV_HI = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_LINE   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MODEM  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_LEVEL  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_TOP    = 3'd7;

    // Feature control bit positions
    localparam int FC_HYST_LO = 0;
    localparam int FC_HYST_HI = 1;
    localparam int FC_RXINV   = 2;
    localparam int FC_DIRSEL  = 3;
    localparam int FC_SWAP    = 6;
    localparam int FC_TXSIDE  = 7;

    // Modem control bit that drives OP1 in general-purpose mode
    localparam int MC_OP1 = 2;

    // Register target of one bus access
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DIV_LO,
        SEL_DIV_HI,
        SEL_ID,
        SEL_REV,
        SEL_LINE,
        SEL_MODEM,
        SEL_SCRATCH,
        SEL_LEVEL_RD,
        SEL_COUNT,
        SEL_TRIG,
        SEL_FEAT
    } uxr_sel_e;

endpackage

// File: rtl/uxr_bank_decode.sv
// Bank decoder: maps the offset and the current line control value to a
// read target and a write target. Purely combinational.
// Assumes the caller gates the write target with the write strobe.
module uxr_bank_decode
    import uxr_pkg::*;
#(
    parameter logic [DATA_W-1:0] EXT_KEY = 8'hBF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] lcr,
    input  logic              div_zero,
    input  logic              scratch_swap,
    output uxr_sel_e          rd_sel,
    output uxr_sel_e          wr_sel
);

    logic ext_bank;
    logic div_bank;

    // Bank flags taken from the line control value
    always_comb begin
        ext_bank = (lcr == EXT_KEY);
        div_bank = lcr[DATA_W-1];
    end

    // Per-offset target selection for reads and writes
    always_comb begin
        rd_sel = SEL_NONE;
        wr_sel = SEL_NONE;
        case (addr)
            OFS_DIV_LO: begin
                if (div_bank) begin
                    wr_sel = SEL_DIV_LO;
                    rd_sel = (ext_bank && div_zero) ? SEL_ID : SEL_DIV_LO;
                end
            end
            OFS_DIV_HI: begin
                if (div_bank) begin
                    wr_sel = SEL_DIV_HI;
                    rd_sel = (ext_bank && div_zero) ? SEL_REV : SEL_DIV_HI;
                end
            end
            OFS_LINE: begin
                wr_sel = SEL_LINE;
                rd_sel = SEL_LINE;
            end
            OFS_MODEM: begin
                wr_sel = SEL_MODEM;
                rd_sel = SEL_MODEM;
            end
            OFS_COUNT: begin
                if (ext_bank) begin
                    rd_sel = SEL_COUNT;
                end
            end
            OFS_LEVEL: begin
                if (ext_bank) begin
                    wr_sel = SEL_TRIG;
                    rd_sel = SEL_TRIG;
                end
            end
            OFS_TOP: begin
                if (ext_bank) begin
                    wr_sel = SEL_FEAT;
                    rd_sel = SEL_FEAT;
                end else begin
                    wr_sel = SEL_SCRATCH;
                    rd_sel = scratch_swap ? SEL_LEVEL_RD : SEL_SCRATCH;
                end
            end
            default: begin
                rd_sel = SEL_NONE;
                wr_sel = SEL_NONE;
            end
        endcase
    end

endmodule

// File: rtl/uxr_cfg_regs.sv
// Configuration register file: holds the divisor bytes, line and modem
// control, scratch, feature control and the two trigger levels.
// Assumes wr_sel is only meaningful while wr_en is high.
module uxr_cfg_regs
    import uxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  uxr_sel_e          wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] div_lo,
    output logic [DATA_W-1:0] div_hi,
    output logic [DATA_W-1:0] lcr,
    output logic [DATA_W-1:0] mcr,
    output logic [DATA_W-1:0] scratch,
    output logic [DATA_W-1:0] feat,
    output logic [DATA_W-1:0] rx_level,
    output logic [DATA_W-1:0] tx_level
);

    logic trig_wr;

    // A trigger write is routed by the direction bit of feature control
    always_comb begin
        trig_wr = wr_en && (wr_sel == SEL_TRIG);
    end

    // Divisor latch bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo <= '0;
            div_hi <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_DIV_LO) div_lo <= wdata;
            if (wr_sel == SEL_DIV_HI) div_hi <= wdata;
        end
    end

    // Line and modem control bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr <= '0;
            mcr <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_LINE)  lcr <= wdata;
            if (wr_sel == SEL_MODEM) mcr <= wdata;
        end
    end

    // Scratch and feature control bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch <= '0;
            feat    <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_SCRATCH) scratch <= wdata;
            if (wr_sel == SEL_FEAT)    feat    <= wdata;
        end
    end

    // Receive and transmit trigger levels, steered by the side bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_level <= '0;
            tx_level <= '0;
        end else if (trig_wr) begin
            if (feat[FC_TXSIDE]) tx_level <= wdata;
            else                 rx_level <= wdata;
        end
    end

endmodule

// File: rtl/uxr_read_port.sv
// Read path: selects the byte for the decoded read target and registers it
// on the read strobe. Holds the last value between reads.
// Assumes CNT_W is at most the data width; counts are zero-extended.
module uxr_read_port
    import uxr_pkg::*;
#(
    parameter int                CNT_W   = 8,
    parameter logic [DATA_W-1:0] DEV_ID  = 8'h14,
    parameter logic [DATA_W-1:0] DEV_REV = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  uxr_sel_e          rd_sel,
    input  logic [DATA_W-1:0] div_lo,
    input  logic [DATA_W-1:0] div_hi,
    input  logic [DATA_W-1:0] lcr,
    input  logic [DATA_W-1:0] mcr,
    input  logic [DATA_W-1:0] scratch,
    input  logic [DATA_W-1:0] feat,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [CNT_W-1:0]  tx_cnt,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cnt_sel;
    logic [DATA_W-1:0] rd_mux;

    // FIFO count chosen by the side bit, widened to the bus
    always_comb begin
        cnt_sel = feat[FC_TXSIDE] ? DATA_W'(tx_cnt) : DATA_W'(rx_cnt);
    end

    // Byte selection per read target
    always_comb begin
        case (rd_sel)
            SEL_DIV_LO:   rd_mux = div_lo;
            SEL_DIV_HI:   rd_mux = div_hi;
            SEL_ID:       rd_mux = DEV_ID;
            SEL_REV:      rd_mux = DEV_REV;
            SEL_LINE:     rd_mux = lcr;
            SEL_MODEM:    rd_mux = mcr;
            SEL_SCRATCH:  rd_mux = scratch;
            SEL_LEVEL_RD: rd_mux = cnt_sel;
            SEL_COUNT:    rd_mux = cnt_sel;
            SEL_FEAT:     rd_mux = feat;
            default:      rd_mux = '0;
        endcase
    end

    // Capture the selected byte on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/uxr_pin_map.sv
// Pin mapping: turns feature control and modem control into the pad-side
// outputs (hysteresis select, IrDA receive polarity, OP1 source).
// Purely combinational; assumes rx_in is already synchronised.
module uxr_pin_map
    import uxr_pkg::*;
(
    input  logic [DATA_W-1:0] feat,
    input  logic              mcr_op1,
    input  logic              rs485_dir,
    input  logic              rx_in,
    output logic [1:0]        rts_hyst,
    output logic              irda_rx_out,
    output logic              op1_out
);

    // Feature-driven pad outputs
    always_comb begin
        rts_hyst    = feat[FC_HYST_HI:FC_HYST_LO];
        irda_rx_out = rx_in ^ feat[FC_RXINV];
        op1_out     = feat[FC_DIRSEL] ? rs485_dir : mcr_op1;
    end

endmodule

// File: rtl/uxr_regbank.sv
// UART channel register bank with a keyed extended set.
// Ties together the bank decoder, the register file, the read port and the
// pad mapping. Assumes single-cycle strobes and never both strobes at once.
module uxr_regbank
    import uxr_pkg::*;
#(
    parameter int                CNT_W   = 8,
    parameter logic [7:0]        EXT_KEY = 8'hBF,
    parameter logic [7:0]        DEV_ID  = 8'h14,
    parameter logic [7:0]        DEV_REV = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [CNT_W-1:0] rx_fifo_cnt,
    input  logic [CNT_W-1:0] tx_fifo_cnt,
    input  logic             rs485_dir,
    input  logic             rx_in,
    output logic [15:0]      divisor,
    output logic [7:0]       rx_trig,
    output logic [7:0]       tx_trig,
    output logic [1:0]       rts_hyst,
    output logic             irda_rx_out,
    output logic             op1_out,
    output logic [7:0]       lcr_cfg,
    output logic [7:0]       mcr_cfg
);

    uxr_sel_e          rd_sel;
    uxr_sel_e          wr_sel;
    logic [DATA_W-1:0] div_lo;
    logic [DATA_W-1:0] div_hi;
    logic [DATA_W-1:0] lcr;
    logic [DATA_W-1:0] mcr;
    logic [DATA_W-1:0] scratch;
    logic [DATA_W-1:0] feat;
    logic              div_zero;

    // Divisor assembly and zero detection for the ID window
    always_comb begin
        divisor  = {div_hi, div_lo};
        div_zero = (divisor == '0);
        lcr_cfg  = lcr;
        mcr_cfg  = mcr;
    end

    uxr_bank_decode #(
        .EXT_KEY (EXT_KEY)
    ) u_decode (
        .addr         (addr),
        .lcr          (lcr),
        .div_zero     (div_zero),
        .scratch_swap (feat[FC_SWAP]),
        .rd_sel       (rd_sel),
        .wr_sel       (wr_sel)
    );

    uxr_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wdata    (wdata),
        .div_lo   (div_lo),
        .div_hi   (div_hi),
        .lcr      (lcr),
        .mcr      (mcr),
        .scratch  (scratch),
        .feat     (feat),
        .rx_level (rx_trig),
        .tx_level (tx_trig)
    );

    uxr_read_port #(
        .CNT_W   (CNT_W),
        .DEV_ID  (DEV_ID),
        .DEV_REV (DEV_REV)
    ) u_read (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .div_lo  (div_lo),
        .div_hi  (div_hi),
        .lcr     (lcr),
        .mcr     (mcr),
        .scratch (scratch),
        .feat    (feat),
        .rx_cnt  (rx_fifo_cnt),
        .tx_cnt  (tx_fifo_cnt),
        .rdata   (rdata)
    );

    uxr_pin_map u_pins (
        .feat        (feat),
        .mcr_op1     (mcr[MC_OP1]),
        .rs485_dir   (rs485_dir),
        .rx_in       (rx_in),
        .rts_hyst    (rts_hyst),
        .irda_rx_out (irda_rx_out),
        .op1_out     (op1_out)
    );

endmodule

// File: rtl/uxr_regbank_chk.sv
// Assertion checker for uxr_regbank, attached through bind.
// Observes only the ports of the top module.
module uxr_regbank_chk #(
    parameter int         CNT_W   = 8,
    parameter logic [7:0] EXT_KEY = 8'hBF,
    parameter logic [7:0] DEV_ID  = 8'h14
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       addr,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       wdata,
    input logic [7:0]       rdata,
    input logic [CNT_W-1:0] rx_fifo_cnt,
    input logic [CNT_W-1:0] tx_fifo_cnt,
    input logic             rx_in,
    input logic [15:0]      divisor,
    input logic [7:0]       rx_trig,
    input logic [7:0]       tx_trig,
    input logic             irda_rx_out,
    input logic             op1_out,
    input logic [7:0]       lcr_cfg,
    input logic [7:0]       mcr_cfg
);

    AST_DIV_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lcr_cfg[7] && addr == 3'd0) |=> (divisor[7:0] == $past(wdata))); // R3

    AST_LOW_OFS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !lcr_cfg[7] && addr <= 3'd2) |=>
        ($stable(divisor) && $stable(rx_trig) && $stable(tx_trig) && $stable(lcr_cfg))); // R3

    AST_ID_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lcr_cfg == EXT_KEY && addr == 3'd0 && divisor == 16'd0) |=> (rdata == DEV_ID)); // R5

    AST_TRIG_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && lcr_cfg == EXT_KEY && addr == 3'd6) |=> (rdata == 8'h00)); // R6

    AST_COUNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lcr_cfg == EXT_KEY && addr == 3'd5) |=>
        ($stable(divisor) && $stable(rx_trig) && $stable(tx_trig) && $stable(mcr_cfg))); // R7

    AST_RXINV_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lcr_cfg == EXT_KEY && addr == 3'd7) |=> (irda_rx_out == (rx_in ^ $past(wdata[2])))); // R10

    AST_OP1_GP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lcr_cfg == EXT_KEY && addr == 3'd7 && !wdata[3]) |=> (op1_out == mcr_cfg[2])); // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rdata)); // R12

endmodule

bind uxr_regbank uxr_regbank_chk #(
    .CNT_W   (CNT_W),
    .EXT_KEY (EXT_KEY),
    .DEV_ID  (DEV_ID)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .rx_fifo_cnt (rx_fifo_cnt),
    .tx_fifo_cnt (tx_fifo_cnt),
    .rx_in       (rx_in),
    .divisor     (divisor),
    .rx_trig     (rx_trig),
    .tx_trig     (tx_trig),
    .irda_rx_out (irda_rx_out),
    .op1_out     (op1_out),
    .lcr_cfg     (lcr_cfg),
    .mcr_cfg     (mcr_cfg)
);

// File: tb/uxr_regbank_tb.sv
// Bench for uxr_regbank: directed corner cases, then seeded random traffic,
// all compared against a register model kept in the bench.
module uxr_regbank_tb;

    localparam logic [7:0] KEY = 8'hBF;
    localparam logic [7:0] ID  = 8'h14;
    localparam logic [7:0] REV = 8'h01;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] rx_fifo_cnt = '0;
    logic [7:0] tx_fifo_cnt = '0;
    logic       rs485_dir = 1'b0;
    logic       rx_in = 1'b0;
    logic [15:0] divisor;
    logic [7:0] rx_trig, tx_trig, lcr_cfg, mcr_cfg;
    logic [1:0] rts_hyst;
    logic       irda_rx_out, op1_out;

    int n_chk = 0;
    int n_bad = 0;

    // Bench register model
    logic [7:0] m_lo, m_hi, m_lcr, m_mcr, m_spr, m_fc, m_rxt, m_txt;

    always #2 clk = ~clk;

    uxr_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_fifo_cnt(rx_fifo_cnt),
        .tx_fifo_cnt(tx_fifo_cnt), .rs485_dir(rs485_dir), .rx_in(rx_in),
        .divisor(divisor), .rx_trig(rx_trig), .tx_trig(tx_trig),
        .rts_hyst(rts_hyst), .irda_rx_out(irda_rx_out), .op1_out(op1_out),
        .lcr_cfg(lcr_cfg), .mcr_cfg(mcr_cfg)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] model_cnt();
        return m_fc[7] ? tx_fifo_cnt : rx_fifo_cnt;
    endfunction

    function automatic logic [7:0] model_read(input logic [2:0] a);
        logic ext;
        logic dzero;
        ext   = (m_lcr == KEY);
        dzero = ({m_hi, m_lo} == 16'd0);
        case (a)
            3'd0: return !m_lcr[7] ? 8'h00 : ((ext && dzero) ? ID  : m_lo);
            3'd1: return !m_lcr[7] ? 8'h00 : ((ext && dzero) ? REV : m_hi);
            3'd3: return m_lcr;
            3'd4: return m_mcr;
            3'd5: return ext ? model_cnt() : 8'h00;
            3'd7: return ext ? m_fc : (m_fc[6] ? model_cnt() : m_spr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        logic ext;
        ext = (m_lcr == KEY);
        if (a == 3'd0 && m_lcr[7]) m_lo = d;
        if (a == 3'd1 && m_lcr[7]) m_hi = d;
        if (a == 3'd3) m_lcr = d;
        if (a == 3'd4) m_mcr = d;
        if (a == 3'd6 && ext) begin
            if (m_fc[7]) m_txt = d;
            else         m_rxt = d;
        end
        if (a == 3'd7) begin
            if (ext) m_fc  = d;
            else     m_spr = d;
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(input string tag, input logic [2:0] a);
        logic [7:0] exp;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp = model_read(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(tag, {8'h00, rdata}, {8'h00, exp});
    endtask

    task automatic check_outputs(input string tag);
        check({tag, " R3 divisor"}, divisor, {m_hi, m_lo});
        check({tag, " R6 rx_trig"}, {8'h00, rx_trig}, {8'h00, m_rxt});
        check({tag, " R6 tx_trig"}, {8'h00, tx_trig}, {8'h00, m_txt});
        check({tag, " R2 lcr_cfg"}, {8'h00, lcr_cfg}, {8'h00, m_lcr});
        check({tag, " R2 mcr_cfg"}, {8'h00, mcr_cfg}, {8'h00, m_mcr});
        check({tag, " R9 rts_hyst"}, {14'd0, rts_hyst}, {14'd0, m_fc[1:0]});
        check({tag, " R10 irda"}, {15'd0, irda_rx_out}, {15'd0, rx_in ^ m_fc[2]});
        check({tag, " R11 op1"}, {15'd0, op1_out}, {15'd0, m_fc[3] ? rs485_dir : m_mcr[2]});
    endtask

    // Watchdog: a hung run is one failed check
    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd20240611));
        {m_lo, m_hi, m_lcr, m_mcr, m_spr, m_fc, m_rxt, m_txt} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_outputs("R1 reset");
        rx_in = 1'b1;
        #1 check("R1 irda passthrough", {15'd0, irda_rx_out}, 16'd1);
        bus_read("R1 scratch reset", 3'd7);

        // R3: low offsets closed while line control bit 7 is clear
        bus_write(3'd0, 8'h55);
        bus_write(3'd2, 8'h66);
        check_outputs("R3 closed write");
        bus_read("R3 closed read", 3'd0);

        // R5: ID and revision with zero divisor
        bus_write(3'd3, KEY);
        bus_read("R5 id", 3'd0);
        bus_read("R5 rev", 3'd1);
        bus_write(3'd1, 8'h02);
        bus_read("R5 div lo after nonzero", 3'd0);
        bus_read("R5 div hi after nonzero", 3'd1);
        check_outputs("R5 div");

        // R6: trigger steering and write-only read
        bus_write(3'd6, 8'h20);
        bus_write(3'd7, 8'h80);
        bus_write(3'd6, 8'h40);
        check_outputs("R6 steer");
        bus_read("R6 trig read zero", 3'd6);

        // R7: count select and ignored writes
        rx_fifo_cnt = 8'd17; tx_fifo_cnt = 8'd99;
        bus_read("R7 tx count", 3'd5);
        bus_write(3'd7, 8'h00);
        bus_read("R7 rx count", 3'd5);
        bus_write(3'd5, 8'hFF);
        check_outputs("R7 write ignored");

        // R4: outside the key, offsets 5/6 are closed and 7 is scratch
        bus_write(3'd3, 8'h80);
        bus_write(3'd6, 8'h77);
        bus_read("R4 offset6 closed", 3'd6);
        bus_read("R4 offset5 closed", 3'd5);
        bus_write(3'd7, 8'hA5);
        bus_read("R4 scratch", 3'd7);
        check_outputs("R4 closed");

        // R8: scratch swap shows the FIFO level
        bus_write(3'd3, KEY);
        bus_write(3'd7, 8'h40);
        bus_write(3'd3, 8'h03);
        bus_read("R8 swapped read", 3'd7);
        bus_write(3'd7, 8'h3C);
        bus_write(3'd3, KEY);
        bus_write(3'd7, 8'h00);
        bus_write(3'd3, 8'h03);
        bus_read("R8 scratch kept", 3'd7);

        // R9 R10 R11: pad outputs
        bus_write(3'd4, 8'h04);
        check_outputs("R11 op1 from modem");
        bus_write(3'd3, KEY);
        bus_write(3'd7, 8'h0F);
        rs485_dir = 1'b0; rx_in = 1'b0;
        #1 check_outputs("R10 R11 feature pads");
        rs485_dir = 1'b1;
        #1 check_outputs("R11 direction follow");

        // R12: rdata holds between reads
        bus_read("R12 read", 3'd4);
        held = rdata;
        bus_write(3'd4, 8'h99);
        repeat (3) @(negedge clk);
        check("R12 hold", {8'h00, rdata}, {8'h00, held});

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [7:0] d;
            op = int'($urandom % 10);
            if ($urandom % 8 == 0) begin
                @(negedge clk);
                rx_fifo_cnt = 8'($urandom);
                tx_fifo_cnt = 8'($urandom);
                rs485_dir   = 1'($urandom);
                rx_in       = 1'($urandom);
            end
            if (op < 2) begin
                case ($urandom % 4)
                    0: d = 8'h00;
                    1: d = 8'h80;
                    2: d = KEY;
                    default: d = 8'($urandom);
                endcase
                bus_write(3'd3, d);
            end else if (op < 6) begin
                d = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
                bus_write(3'($urandom), d);
            end else begin
                bus_read("R12 random read", 3'($urandom));
            end
            check_outputs("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule